// File: doc/BRIEF.md
# Page-Mode DRAM Delay-Line Controller

This block turns single-sample requests from an audio datapath into page-mode bursts on an external DRAM with a 4-bit data bus. The DRAM holds circular delay lines, one for each of four audio channels. Each request carries a line base address and, for reads, a delay in samples. The block keeps one write pointer that advances once per audio frame. A read fetches the sample written that many frames earlier, with the delay wrapped inside the line length.

A 16-bit sample is moved in one burst. The burst has one row strobe and four column strobes on a 9-bit multiplexed address bus, and the most significant nibble goes first. All strobe timing is counted in system clock cycles, and one clock cycle stands for one half-period timing unit. A per-request flag picks the larger or the smaller DRAM organisation. Between bursts the block inserts row-only refresh cycles driven by an interval timer.

Top module: `dram_dline_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no request pending, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` and `done` are low, and `req_ready` is high.
- R2: Each accepted request produces exactly one RAS fall followed by exactly four CAS falls. Nibble index n (0..3) is placed in the two low bits of the column address.
- R3: With `req_big`=1 the 16-bit word address w gives row = w[15:7] and column = {w[6:0], n}.
- R4: With `req_big`=0 only w[13:0] is used: row = {0, w[13:6]}, column = {0, w[5:0], n}. Address bit 8 stays low during the burst.
- R5: `dram_amsb_n` is always the inverse of `dram_a[8]`.
- R6: RAS stays high at least T_RP cycles before it falls and stays low at least T_RASMIN cycles. The first CAS fall comes T_RCD cycles after the RAS fall, and later CAS falls are T_CASH+T_CASL (4) cycles apart. CAS is never low while RAS is high.
- R7: On a write, `dram_we_n` is low at every CAS fall, `dram_oe_n` stays high, `dram_dq_oe` is high, and at column n `dram_dq_out` carries bits [15-4n -: 4] of the sample.
- R8: On a read, `dram_oe_n` is low at every CAS fall, `dram_we_n` stays high, and `dram_dq_oe` is low. The nibble sampled at column n lands in `rd_data`[15-4n -: 4]. `done` is a one-cycle pulse in the cycle after the last CAS low phase, and `rd_data` is valid with it.
- R9: A write goes to w = base + p, and a read goes to w = base + ((p - delay) mod 2^LINE_W), both sums mod 2^16. Here p is the write pointer: it is 0 after reset and increments modulo 2^LINE_W on each `frame_tick`.
- R10: Every REF_INTERVAL cycles a refresh is requested. It runs as a RAS-only cycle with CAS high, and its row comes from a counter that starts at 0 and increments by one each refresh, modulo 512. A refresh never splits an access burst.
- R11: A request is taken only when `req_ready` is high. `req_ready` goes low in the cycle after acceptance, and `req_valid` is ignored while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one cycle per timing unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | Advances the shared write pointer |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_big | input | 1 | 1 larger DRAM organisation, 0 smaller |
| req_base | input | 16 | Delay-line base word address |
| req_delay | input | LINE_W | Read delay in samples |
| req_wdata | input | 16 | Sample to write |
| rd_data | output | 16 | Assembled read sample |
| done | output | 1 | Burst finished pulse |
| dram_a | output | 9 | Multiplexed row/column address |
| dram_amsb_n | output | 1 | Inverse of address bit 8 |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Write nibble |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | 4 | Read nibble |

## Verification
A wrong write pointer or a wrong delay subtraction shows up at the row and column addresses of the very next burst. A wrong organisation mapping shows up the same way, and a wrong nibble ordering shows up in the data or in `rd_data` at the `done` pulse. A sequencer stuck in the wrong state or counting wrong shows up within one burst: the strobe spacing measured at the pins changes, the count of CAS falls per RAS-low changes, or a request is taken while busy. Refresh errors show up at the next refresh row, which the bench follows across every refresh in the run.

// File: rtl/dl_pkg.sv
package dl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_CH,
      ST_CL,
      ST_PRE,
      ST_REF
   } dl_state_e;
endpackage

// File: rtl/dl_addr_map.sv
module dl_addr_map #(
   parameter int A_W    = 9,
   parameter int NI_W   = 2,
   parameter int LINE_W = 14,
   localparam int WA_W  = 2*A_W - NI_W,
   localparam int CH_W  = A_W - NI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic [WA_W-1:0]   base,
   input  logic [LINE_W-1:0] delay,
   input  logic              is_wr,
   input  logic              big,
   output logic [A_W-1:0]    row,
   output logic [CH_W-1:0]   col_hi
);
   logic [LINE_W-1:0] wptr;
   logic [LINE_W-1:0] off;
   logic [WA_W-1:0]   off_ext;
   logic [WA_W-1:0]   waddr;

   if (LINE_W > WA_W - 2) begin : g_bad_line
      $error("dl_addr_map: LINE_W must fit the smaller organisation");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wptr <= '0;
      else if (frame_tick) wptr <= wptr + 1'b1;
   end

   assign off = is_wr ? wptr : wptr - delay;

   if (LINE_W < WA_W) begin : g_ext
      assign off_ext = {{(WA_W-LINE_W){1'b0}}, off};
   end else begin : g_full
      assign off_ext = off;
   end

   assign waddr = base + off_ext;

   always_comb begin
      if (big) begin
         row    = waddr[WA_W-1 -: A_W];
         col_hi = waddr[CH_W-1:0];
      end else begin
         row    = {1'b0, waddr[WA_W-3 -: A_W-1]};
         col_hi = {1'b0, waddr[CH_W-2:0]};
      end
   end
endmodule

// File: rtl/dl_refresh.sv
module dl_refresh #(
   parameter int A_W          = 9,
   parameter int REF_INTERVAL = 1000,
   localparam int RC_W        = $clog2(REF_INTERVAL + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ack,
   output logic           pend,
   output logic [A_W-1:0] row
);
   logic [RC_W-1:0] tmr;

   if (REF_INTERVAL < 64) begin : g_bad_ivl
      $error("dl_refresh: REF_INTERVAL too short to let bursts through");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr  <= RC_W'(REF_INTERVAL - 1);
         pend <= 1'b0;
         row  <= '0;
      end else begin
         if (tmr == '0) tmr <= RC_W'(REF_INTERVAL - 1);
         else           tmr <= tmr - 1'b1;
         if (ack) begin
            pend <= 1'b0;
            row  <= row + 1'b1;
         end else if (tmr == '0) begin
            pend <= 1'b1;
         end
      end
   end

   a_r10_ack_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> pend);
endmodule

// File: rtl/dl_seq.sv
module dl_seq
   import dl_pkg::*;
#(
   parameter int A_W      = 9,
   parameter int D_W      = 16,
   parameter int NB_W     = 4,
   parameter int T_RCD    = 4,
   parameter int T_CASH   = 2,
   parameter int T_CASL   = 2,
   parameter int T_RP     = 4,
   parameter int T_RASMIN = 16,
   localparam int NIBS    = D_W / NB_W,
   localparam int NI_W    = $clog2(NIBS),
   localparam int CH_W    = A_W - NI_W,
   localparam int CNT_W   = $clog2(T_RASMIN + T_RCD + T_RP + 1) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_write,
   input  logic            req_big,
   input  logic [D_W-1:0]  req_wdata,
   input  logic [A_W-1:0]  map_row,
   input  logic [CH_W-1:0] map_col_hi,
   input  logic            ref_pend,
   input  logic [A_W-1:0]  ref_row,
   output logic            ref_ack,
   output logic [D_W-1:0]  rd_data,
   output logic            done,
   output logic [A_W-1:0]  dram_a,
   output logic            dram_ras_n,
   output logic            dram_cas_n,
   output logic            dram_we_n,
   output logic            dram_oe_n,
   output logic [NB_W-1:0] dram_dq_out,
   output logic            dram_dq_oe,
   input  logic [NB_W-1:0] dram_dq_in
);
   localparam int ROWC = T_RCD - T_CASH;

   dl_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [NI_W-1:0]  nib;
   logic             is_wr;
   logic             big_q;
   logic [A_W-1:0]   row_q;
   logic [CH_W-1:0]  colhi_q;
   logic [D_W-1:0]   wdata_q;
   logic [D_W-1:0]   rd_q;
   logic [NB_W-1:0]  wlane [NIBS];
   logic             in_acc, in_col, last_cl;

   for (genvar g = 0; g < NIBS; g++) begin : g_lane
      assign wlane[g] = wdata_q[D_W-1-g*NB_W -: NB_W];
   end

   assign req_ready = (state == ST_IDLE) && !ref_pend;
   assign ref_ack   = (state == ST_IDLE) && ref_pend;
   assign last_cl   = (state == ST_CL) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         nib     <= '0;
         is_wr   <= 1'b0;
         big_q   <= 1'b0;
         row_q   <= '0;
         colhi_q <= '0;
         wdata_q <= '0;
         rd_q    <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (ref_pend) begin
                  state <= ST_REF;
                  cnt   <= CNT_W'(T_RASMIN - 1);
                  row_q <= ref_row;
               end else if (req_valid) begin
                  state   <= ST_ROW;
                  cnt     <= CNT_W'(ROWC - 1);
                  row_q   <= map_row;
                  colhi_q <= map_col_hi;
                  is_wr   <= req_write;
                  big_q   <= req_big;
                  wdata_q <= req_wdata;
                  nib     <= '0;
               end
            end
            ST_ROW: begin
               if (cnt == '0) begin
                  state <= ST_CH;
                  cnt   <= CNT_W'(T_CASH - 1);
               end else cnt <= cnt - 1'b1;
            end
            ST_CH: begin
               if (cnt == '0) begin
                  state <= ST_CL;
                  cnt   <= CNT_W'(T_CASL - 1);
               end else cnt <= cnt - 1'b1;
            end
            ST_CL: begin
               if (cnt == '0) begin
                  if (!is_wr) begin
                     for (int k = 0; k < NIBS; k++) begin
                        if (nib == NI_W'(k)) rd_q[D_W-1-k*NB_W -: NB_W] <= dram_dq_in;
                     end
                  end
                  if (nib == NI_W'(NIBS - 1)) begin
                     state <= ST_PRE;
                     cnt   <= CNT_W'(T_RP - 1);
                     done  <= 1'b1;
                  end else begin
                     nib   <= nib + 1'b1;
                     state <= ST_CH;
                     cnt   <= CNT_W'(T_CASH - 1);
                  end
               end else cnt <= cnt - 1'b1;
            end
            ST_REF: begin
               if (cnt == '0) begin
                  state <= ST_PRE;
                  cnt   <= CNT_W'(T_RP - 1);
               end else cnt <= cnt - 1'b1;
            end
            default: begin
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
         endcase
      end
   end

   assign in_col = (state == ST_CH) || (state == ST_CL);
   assign in_acc = (state == ST_ROW) || in_col;

   assign dram_ras_n  = !(in_acc || (state == ST_REF));
   assign dram_cas_n  = (state != ST_CL);
   assign dram_we_n   = !(is_wr && in_acc);
   assign dram_oe_n   = !(!is_wr && in_col);
   assign dram_dq_oe  = is_wr && in_col;
   assign dram_dq_out = wlane[nib];
   assign dram_a      = in_col ? {colhi_q, nib} :
                        ((state == ST_ROW) || (state == ST_REF)) ? row_q : '0;
   assign rd_data     = rd_q;

   // Pin-level watch counters for the timing properties below.
   logic [7:0] lo_cnt, hi_cnt;
   logic [2:0] cas_falls;
   logic       cas_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt    <= '0;
         hi_cnt    <= 8'hFF;
         cas_falls <= '0;
         cas_d     <= 1'b1;
      end else begin
         cas_d <= dram_cas_n;
         if (dram_ras_n) begin
            lo_cnt    <= '0;
            cas_falls <= '0;
            if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
         end else begin
            hi_cnt <= '0;
            if (lo_cnt != 8'hFF) lo_cnt <= lo_cnt + 1'b1;
            if (cas_d && !dram_cas_n) cas_falls <= cas_falls + 1'b1;
         end
      end
   end

   a_r6_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);
   a_r6_ras_low_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |-> (lo_cnt >= 8'(T_RASMIN)));
   a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (hi_cnt >= 8'(T_RP)));
   a_r10_no_split: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |-> (cas_falls == 3'd0 || cas_falls == 3'(NIBS)));
   a_r7_no_bus_clash: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dram_we_n && !dram_oe_n));
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r11_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!dram_ras_n && !req_ready));
   a_r4_small_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (!big_q && in_acc) |-> !dram_a[A_W-1]);
endmodule

// File: rtl/dram_dline_ctrl.sv
module dram_dline_ctrl #(
   parameter int A_W          = 9,
   parameter int D_W          = 16,
   parameter int NB_W         = 4,
   parameter int LINE_W       = 14,
   parameter int T_RCD        = 4,
   parameter int T_CASH       = 2,
   parameter int T_CASL       = 2,
   parameter int T_RP         = 4,
   parameter int T_RASMIN     = 16,
   parameter int REF_INTERVAL = 1000,
   localparam int NIBS        = D_W / NB_W,
   localparam int NI_W        = $clog2(NIBS),
   localparam int WA_W        = 2*A_W - NI_W,
   localparam int CH_W        = A_W - NI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_big,
   input  logic [WA_W-1:0]   req_base,
   input  logic [LINE_W-1:0] req_delay,
   input  logic [D_W-1:0]    req_wdata,
   output logic [D_W-1:0]    rd_data,
   output logic              done,
   output logic [A_W-1:0]    dram_a,
   output logic              dram_amsb_n,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [NB_W-1:0]   dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [NB_W-1:0]   dram_dq_in
);
   if (D_W != NIBS * NB_W || NIBS < 2)   begin : g_bad_width
      $error("dram_dline_ctrl: D_W must be a multiple of NB_W");
   end
   if (T_RCD < 2 || T_RCD > 5 || T_RCD <= T_CASH) begin : g_bad_rcd
      $error("dram_dline_ctrl: T_RCD out of range");
   end
   if (T_CASH < 1 || T_CASL < 1 || T_RP < 4) begin : g_bad_strobe
      $error("dram_dline_ctrl: strobe phases too short");
   end
   if (T_RCD - T_CASH + NIBS*(T_CASH+T_CASL) < T_RASMIN) begin : g_bad_ras
      $error("dram_dline_ctrl: burst shorter than minimum RAS low");
   end

   logic [A_W-1:0]  map_row, ref_row;
   logic [CH_W-1:0] map_col_hi;
   logic            ref_pend, ref_ack;

   dl_addr_map #(.A_W(A_W), .NI_W(NI_W), .LINE_W(LINE_W)) u_map (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .base(req_base), .delay(req_delay), .is_wr(req_write), .big(req_big),
      .row(map_row), .col_hi(map_col_hi)
   );

   dl_refresh #(.A_W(A_W), .REF_INTERVAL(REF_INTERVAL)) u_ref (
      .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend), .row(ref_row)
   );

   dl_seq #(
      .A_W(A_W), .D_W(D_W), .NB_W(NB_W), .T_RCD(T_RCD), .T_CASH(T_CASH),
      .T_CASL(T_CASL), .T_RP(T_RP), .T_RASMIN(T_RASMIN)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_big(req_big), .req_wdata(req_wdata),
      .map_row(map_row), .map_col_hi(map_col_hi),
      .ref_pend(ref_pend), .ref_row(ref_row), .ref_ack(ref_ack),
      .rd_data(rd_data), .done(done),
      .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
      .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
      .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
   );

   assign dram_amsb_n = ~dram_a[A_W-1];

   a_r5_msb_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_amsb_n != dram_a[A_W-1]));
endmodule

// File: tb/dram_dline_ctrl_test.sv
`timescale 1ns/1ps
module dram_dline_ctrl_test;
   localparam int LW = 4;
   localparam int LEN = 16;
   localparam int RCD = 4;
   localparam int RP = 4;
   localparam int RASMIN = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_tick = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_big = 1'b0;
   logic [15:0] req_base = '0, req_wdata = '0;
   logic [LW-1:0] req_delay = '0;
   logic req_ready, done, dram_amsb_n, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [15:0] rd_data;
   logic [8:0] dram_a;
   logic [3:0] dram_dq_out, dram_dq_in;

   always #2 clk = ~clk;

   dram_dline_ctrl #(.LINE_W(LW), .REF_INTERVAL(300)) uut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_big(req_big), .req_base(req_base), .req_delay(req_delay),
      .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
      .dram_a(dram_a), .dram_amsb_n(dram_amsb_n), .dram_ras_n(dram_ras_n),
      .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
      .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
   );

   int tests = 0, fails = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] nib_f(input logic [8:0] r, input logic [8:0] c);
      return c[3:0] ^ c[7:4] ^ r[3:0] ^ {r[8], c[8], r[5:4]};
   endfunction

   // Pin monitor
   logic [8:0] brow = '0;
   int ncyc = 0, t_fall = 0, t_last = 0, hi_cnt = 100, lo_cnt = 0, ncas = 0;
   int tim_err = 0, a8_err = 0, split_err = 0, ref_err = 0, nref = 0, nburst = 0;
   int wel = 0, oel = 0, dqoe = 0;
   logic [8:0] exp_ref = '0;
   logic [8:0] rec_col [4];
   logic [3:0] rec_dq [4];
   logic ras_p = 1'b1, cas_p = 1'b1;

   assign dram_dq_in = dram_oe_n ? 4'h0 : nib_f(brow, dram_a);

   always @(negedge clk) begin
      ncyc++;
      if (rst_n) begin
         if (dram_amsb_n !== ~dram_a[8]) a8_err++;
         if (ras_p && !dram_ras_n) begin
            brow = dram_a; ncas = 0; t_fall = ncyc; wel = 0; oel = 0; dqoe = 0;
            if (hi_cnt < RP) tim_err++;
         end
         if (cas_p && !dram_cas_n && ncas < 4) begin
            if (ncas == 0) begin if (ncyc - t_fall != RCD) tim_err++; end
            else if (ncyc - t_last != 4) tim_err++;
            t_last = ncyc;
            rec_col[ncas] = dram_a; rec_dq[ncas] = dram_dq_out;
            if (!dram_we_n) wel++;
            if (!dram_oe_n) oel++;
            if (dram_dq_oe) dqoe++;
            ncas++;
         end
         if (!ras_p && dram_ras_n) begin
            if (ncas == 0) begin
               if (brow != exp_ref) ref_err++;
               exp_ref = exp_ref + 1'b1; nref++;
            end else if (ncas != 4) split_err++;
            else nburst++;
            if (lo_cnt < RASMIN) tim_err++;
         end
         if (!dram_cas_n && dram_ras_n) tim_err++;
         if (dram_ras_n) begin hi_cnt++; lo_cnt = 0; end
         else begin lo_cnt++; hi_cnt = 0; end
         ras_p = dram_ras_n; cas_p = dram_cas_n;
      end
   end

   int wptr_m = 0;

   task automatic tick();
      @(posedge clk); #1 frame_tick = 1'b1;
      @(posedge clk); #1 frame_tick = 1'b0;
      wptr_m = (wptr_m + 1) % LEN;
   endtask

   task automatic access(input bit wr, input logic [15:0] base, input int dly,
                         input bit big, input logic [15:0] data);
      logic [15:0] w;
      logic [8:0] erow, ecol;
      logic [15:0] eword;
      int off;
      off = wr ? wptr_m : (wptr_m - dly + LEN) % LEN;
      w = base + 16'(off);
      if (big) erow = w[15:7]; else erow = {1'b0, w[13:6]};
      @(posedge clk); #1;
      while (!req_ready) begin @(posedge clk); #1; end
      req_valid = 1'b1; req_write = wr; req_big = big; req_base = base;
      req_delay = LW'(dly); req_wdata = data;
      @(posedge clk); #1;
      req_valid = 1'b0;
      check(!req_ready, "R11 ready drops after accept", req_ready, 0);
      @(negedge clk);
      while (!done) @(negedge clk);
      check(brow == erow, wr ? "R3/R4 write row" : "R3/R4 read row", brow, erow);
      eword = '0;
      for (int n = 0; n < 4; n++) begin
         if (big) ecol = {w[6:0], 2'(n)}; else ecol = {1'b0, w[5:0], 2'(n)};
         check(rec_col[n] == ecol, big ? "R3 column" : "R4 column", rec_col[n], ecol);
         eword = eword | (16'(nib_f(erow, ecol)) << (12 - 4*n));
         if (wr) check(rec_dq[n] == data[15-4*n -: 4], "R7 write nibble order", rec_dq[n], data[15-4*n -: 4]);
      end
      check(ncas == 4, "R2 four CAS per burst", ncas, 4);
      if (wr) begin
         check(wel == 4 && oel == 0 && dqoe == 4, "R7 write strobes", {wel, oel, dqoe}, 32'h040004);
      end else begin
         check(wel == 0 && oel == 4 && dqoe == 0, "R8 read strobes", {wel, oel, dqoe}, 32'h000400);
         check(rd_data == eword, "R8 read word MSB first", rd_data, eword);
      end
      @(negedge clk);
      check(!done, "R8 done one cycle", done, 0);
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int nb0;
      repeat (3) @(negedge clk);
      check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !done,
            "R1 strobes idle in reset", 0, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(req_ready, "R1 ready after reset", req_ready, 1);
      check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle after reset", 0, 0);

      // R9 write sweep across pointer wrap, larger organisation
      for (int i = 0; i < 20; i++) begin
         access(1, 16'h1230, 0, 1, 16'(i) * 16'h1111 ^ 16'hA5C3);
         tick();
      end
      // R9 read sweep over all delays, base near top of space
      for (int d = 0; d < LEN; d++) access(0, 16'hFFF8, d, 1, 16'h0);
      // smaller organisation, 14-bit truncation
      for (int d = 0; d < LEN; d++) access(0, 16'h3FF9, d, 0, 16'h0);
      for (int i = 0; i < 6; i++) begin
         access(1, 16'hC000 + 16'(i * 40), 0, 0, 16'h9E17 + 16'(i));
         tick();
      end

      // R11 request while busy is ignored
      nb0 = nburst;
      @(posedge clk); #1;
      while (!req_ready) begin @(posedge clk); #1; end
      req_valid = 1'b1; req_write = 1'b0; req_big = 1'b1; req_base = 16'h0400; req_delay = '0;
      @(posedge clk); #1 req_valid = 1'b0;
      repeat (5) @(posedge clk);
      #1 req_valid = 1'b1; req_base = 16'h8800;
      @(posedge clk); #1 req_valid = 1'b0;
      repeat (60) @(posedge clk);
      check(nburst - nb0 == 1, "R11 busy request ignored", nburst - nb0, 1);

      // R10 refresh while idle
      repeat (1500) @(posedge clk);
      @(negedge clk);
      check(nref >= 6, "R10 refresh runs", nref, 6);
      check(ref_err == 0, "R10 refresh row sequence", ref_err, 0);
      check(split_err == 0, "R10 burst not split", split_err, 0);
      check(tim_err == 0, "R6 strobe timing", tim_err, 0);
      check(a8_err == 0, "R5 inverted MSB", a8_err, 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule